// File: doc/BRIEF.md
# Double-Buffered Echo Sample Fetcher

This block serves ten parallel index calculators from a single echo-trace buffer. Each incoming trace arrives as a stream of words. A short header comes first and carries the emitter and receiver coordinates. The pressure samples follow. The stream is written into whichever half of a two-sided buffer is not being read. The other half answers lookups for the trace that is currently live.

A group of ten sample indices is captured into a sample register, together with the ten voxel values that the caller has preloaded from external memory. The block then reads the ten samples one per cycle, lane 0 first, through one buffer read port. It adds each sample into its voxel and raises a one-cycle completion pulse, so that the caller can store the sums back. A trace stays live for a fixed number of voxel groups. The two halves exchange roles only when the reader has used up the live trace and the writer holds a complete new one. Whichever side gets there first waits for the other.

Top module: `echo_fetch_top`

## Requirements
- R1: After reset, `trc_ready` is 1, while `trace_live`, `idx_ready`, `grp_done`, `coords_out` and `vox_out` are all 0.
- R2: A trace is HDR+DEPTH accepted words (a word is accepted when `trc_valid` and `trc_ready` are both 1). Header word h, for h from 0 to HDR-1, appears in `coords_out[h*SW +: SW]`. Sample word a+HDR is stored at sample address a. Cycles with `trc_valid` low are skipped.
- R3: Once a complete trace is held and not yet swapped in, `trc_ready` is 0 and no further word is taken.
- R4: A swap happens in the cycle after a complete trace is held, provided the reader is free. The reader is free when no trace is live, or when the live trace has served all GROUPS groups and no group is running. `coords_out` changes, and `trace_live` rises, only in the cycle after a swap.
- R5: `idx_ready` is 1 only while a trace is live, no group is running, and fewer than GROUPS groups have used that trace.
- R6: A group is accepted on a clock edge where `idx_valid` and `idx_ready` are both 1. Its ten samples are fetched one per cycle in lane order. `grp_done` is high for exactly one cycle, starting 10 clock edges after the accepting edge.
- R7: When `grp_done` is high, lane k of `vox_out` equals lane k of the accepted `vox_in` plus the sign-extended two's-complement sample at the address given by lane k of `idx_bus`, wrapped modulo 2^AW.
- R8: Once GROUPS groups have completed on a trace, `idx_ready` stays 0 until the next swap.
- R9: Lookups always read the live trace. Words written for the next trace during a fetch do not change the fetched values.
- R10: `vox_out` holds its value whenever no group is running.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| trc_valid | input | 1 | Trace word present |
| trc_data | input | SW | Trace word: header first, then samples |
| trc_ready | output | 1 | Writer can take a word |
| coords_out | output | HDR*SW | Header words of the live trace |
| trace_live | output | 1 | A trace is available for lookups |
| idx_valid | input | 1 | Index group and voxel preload present |
| idx_bus | input | LANES*IW | Ten sample addresses, lane k at bits k*IW |
| vox_in | input | LANES*AW | Preloaded voxel values, lane k at bits k*AW |
| idx_ready | output | 1 | Group can be accepted |
| vox_out | output | LANES*AW | Accumulated voxel values |
| grp_done | output | 1 | One-cycle pulse when all ten sums are final |

## Verification
Two functions can fall in the same cycle: the buffer fill and the sample lookup. The bench streams the second trace into the idle half while voxel groups are being fetched from the live half. Every fetched sum is compared with the first trace's samples, and the second trace's header must not appear before its swap. A second collision happens on the completion edge of the last group of a trace, when a full trace is already waiting. The bench checks that `idx_ready` is low in the completion cycle, and that the new coordinates and a raised `idx_ready` appear in the cycle right after it.

// File: rtl/esf_pkg.sv
package esf_pkg;
  typedef enum logic {FS_IDLE, FS_RUN} fetch_st_t;
  localparam int unsigned LANES_DEF = 10;
  localparam int unsigned HDR_DEF   = 6;
endpackage

// File: rtl/esf_trace_store.sv
module esf_trace_store #(
  parameter int unsigned SW    = 16,
  parameter int unsigned DEPTH = 64,
  parameter int unsigned HDR   = 6,
  localparam int unsigned IW   = $clog2(DEPTH),
  localparam int unsigned CW   = $clog2(HDR + DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_valid,
  input  logic [SW-1:0]     wr_data,
  input  logic              swap,
  input  logic [IW-1:0]     rd_addr,
  output logic              wr_ready,
  output logic              fill_full,
  output logic [SW-1:0]     rd_data,
  output logic [HDR*SW-1:0] hdr_fill
);
  logic [SW-1:0] mem [2][DEPTH];
  logic [SW-1:0] hdr [2][HDR];
  logic          active;
  logic [CW-1:0] wr_cnt;
  logic          wr_take;
  logic          wr_last;

  assign wr_ready = !fill_full;
  assign wr_take  = wr_valid && wr_ready;
  assign wr_last  = (wr_cnt == CW'(HDR + DEPTH - 1));
  assign rd_data  = mem[active][rd_addr];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active    <= 1'b0;
      wr_cnt    <= '0;
      fill_full <= 1'b0;
    end else begin
      if (swap) begin
        active    <= ~active;
        fill_full <= 1'b0;
      end else if (wr_take) begin
        wr_cnt    <= wr_last ? '0 : wr_cnt + 1'b1;
        fill_full <= wr_last;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (wr_take) begin
      if (wr_cnt < CW'(HDR)) hdr[~active][wr_cnt[$clog2(HDR)-1:0]] <= wr_data;
      else                   mem[~active][IW'(wr_cnt - CW'(HDR))] <= wr_data;
    end
  end

  for (genvar h = 0; h < HDR; h++) begin : g_hdr
    assign hdr_fill[h*SW +: SW] = hdr[~active][h];
  end

  AST_WR_HOLD_WHEN_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    (fill_full && $past(fill_full)) |-> $stable(wr_cnt)); // R3
endmodule

// File: rtl/esf_swap_ctl.sv
module esf_swap_ctl #(
  parameter int unsigned SW  = 16,
  parameter int unsigned HDR = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fill_full,
  input  logic              rd_free,
  input  logic [HDR*SW-1:0] hdr_fill,
  output logic              swap,
  output logic              trace_live,
  output logic [HDR*SW-1:0] coords_out
);
  assign swap = fill_full && rd_free;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      trace_live <= 1'b0;
      coords_out <= '0;
    end else if (swap) begin
      trace_live <= 1'b1;
      coords_out <= hdr_fill;
    end
  end

  AST_SWAP_BRINGS_LIVE: assert property (@(posedge clk) disable iff (!rst_n)
    swap |=> trace_live); // R4
endmodule

// File: rtl/esf_fetch_seq.sv
module esf_fetch_seq
  import esf_pkg::*;
#(
  parameter int unsigned LANES  = 10,
  parameter int unsigned IW     = 6,
  parameter int unsigned SW     = 16,
  parameter int unsigned AW     = 24,
  parameter int unsigned GROUPS = 3,
  localparam int unsigned LW    = $clog2(LANES),
  localparam int unsigned GW    = $clog2(GROUPS + 1)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                idx_valid,
  input  logic [LANES*IW-1:0] idx_bus,
  input  logic [LANES*AW-1:0] vox_in,
  input  logic                trace_live,
  input  logic                swap,
  input  logic [SW-1:0]       rd_data,
  output logic                idx_ready,
  output logic [IW-1:0]       rd_addr,
  output logic [LANES*AW-1:0] vox_out,
  output logic                grp_done,
  output logic                rd_free
);
  function automatic logic [AW-1:0] acc_add(input logic [AW-1:0] v, input logic [SW-1:0] s);
    return v + {{(AW-SW){s[SW-1]}}, s};
  endfunction

  fetch_st_t     st;
  logic [LW-1:0] lane;
  logic [GW-1:0] grp_cnt;
  logic [IW-1:0] idx_q [LANES];
  logic [AW-1:0] vox_q [LANES];
  logic          trace_used;
  logic          accept;
  logic          last_lane;
  logic          running;

  assign running    = (st == FS_RUN);
  assign trace_used = (grp_cnt == GW'(GROUPS));
  assign idx_ready  = trace_live && !running && !trace_used;
  assign rd_free    = !trace_live || (trace_used && !running);
  assign accept     = idx_valid && idx_ready;
  assign last_lane  = (lane == LW'(LANES - 1));
  assign rd_addr    = idx_q[lane];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st       <= FS_IDLE;
      lane     <= '0;
      grp_cnt  <= '0;
      grp_done <= 1'b0;
      for (int k = 0; k < LANES; k++) begin
        idx_q[k] <= '0;
        vox_q[k] <= '0;
      end
    end else begin
      grp_done <= 1'b0;
      if (swap) grp_cnt <= '0;
      if (accept) begin
        st   <= FS_RUN;
        lane <= '0;
        for (int k = 0; k < LANES; k++) begin
          idx_q[k] <= idx_bus[k*IW +: IW];
          vox_q[k] <= vox_in[k*AW +: AW];
        end
      end else if (running) begin
        vox_q[lane] <= acc_add(vox_q[lane], rd_data);
        if (last_lane) begin
          st       <= FS_IDLE;
          lane     <= '0;
          grp_done <= 1'b1;
          grp_cnt  <= grp_cnt + 1'b1;
        end else begin
          lane <= lane + 1'b1;
        end
      end
    end
  end

  for (genvar k = 0; k < LANES; k++) begin : g_out
    assign vox_out[k*AW +: AW] = vox_q[k];
  end

  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    grp_done |=> !grp_done); // R6
  AST_LANE_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    running |-> (lane < LW'(LANES))); // R6
  AST_GROUP_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
    grp_cnt <= GW'(GROUPS)); // R8
  AST_VOX_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(!running) && !running) |-> $stable(vox_out)); // R10
endmodule

// File: rtl/echo_fetch_top.sv
module echo_fetch_top #(
  parameter int unsigned LANES  = 10,
  parameter int unsigned SW     = 16,
  parameter int unsigned AW     = 24,
  parameter int unsigned DEPTH  = 64,
  parameter int unsigned HDR    = 6,
  parameter int unsigned GROUPS = 3,
  localparam int unsigned IW    = $clog2(DEPTH)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                trc_valid,
  input  logic [SW-1:0]       trc_data,
  output logic                trc_ready,
  output logic [HDR*SW-1:0]   coords_out,
  output logic                trace_live,
  input  logic                idx_valid,
  input  logic [LANES*IW-1:0] idx_bus,
  input  logic [LANES*AW-1:0] vox_in,
  output logic                idx_ready,
  output logic [LANES*AW-1:0] vox_out,
  output logic                grp_done
);
  logic              fill_full;
  logic              rd_free;
  logic              swap;
  logic [IW-1:0]     rd_addr;
  logic [SW-1:0]     rd_data;
  logic [HDR*SW-1:0] hdr_fill;

  esf_trace_store #(.SW(SW), .DEPTH(DEPTH), .HDR(HDR)) u_store (
    .clk, .rst_n, .wr_valid(trc_valid), .wr_data(trc_data), .swap,
    .rd_addr, .wr_ready(trc_ready), .fill_full, .rd_data, .hdr_fill);

  esf_swap_ctl #(.SW(SW), .HDR(HDR)) u_swap (
    .clk, .rst_n, .fill_full, .rd_free, .hdr_fill, .swap, .trace_live, .coords_out);

  esf_fetch_seq #(.LANES(LANES), .IW(IW), .SW(SW), .AW(AW), .GROUPS(GROUPS)) u_fetch (
    .clk, .rst_n, .idx_valid, .idx_bus, .vox_in, .trace_live, .swap, .rd_data,
    .idx_ready, .rd_addr, .vox_out, .grp_done, .rd_free);

  AST_COORDS_ONLY_ON_SWAP: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(coords_out) |-> $past(fill_full)); // R4
  AST_READY_NEEDS_LIVE: assert property (@(posedge clk) disable iff (!rst_n)
    idx_ready |-> trace_live); // R5
endmodule

// File: tb/tb_echo_fetch_top.sv
module tb_echo_fetch_top;
  localparam int LANES = 10, SW = 16, AW = 24, DEPTH = 64, HDR = 6, GROUPS = 3, IW = 6;

  typedef struct packed {
    logic [7:0]  ib;
    logic [7:0]  istep;
    logic [23:0] vb;
    logic [23:0] vstep;
  } vec_t;

  localparam vec_t VT [7] = '{
    '{8'd0,  8'd1,  24'd0,       24'd100},
    '{8'd63, 8'd7,  24'h800000,  24'd1},
    '{8'd5,  8'd0,  24'hFFFFF0,  24'd0},
    '{8'd0,  8'd63, 24'd1000,    24'hFFFF00},
    '{8'd32, 8'd32, 24'h7FFFFF,  24'd0},
    '{8'd10, 8'd13, 24'd0,       24'd0},
    '{8'd62, 8'd1,  24'h123456,  24'd3}};

  logic clk = 0, rst_n = 0;
  logic trc_valid = 0;
  logic [SW-1:0] trc_data = '0;
  logic trc_ready, trace_live, idx_ready, grp_done;
  logic [HDR*SW-1:0] coords_out;
  logic idx_valid = 0;
  logic [LANES*IW-1:0] idx_bus = '0;
  logic [LANES*AW-1:0] vox_in = '0;
  logic [LANES*AW-1:0] vox_out;

  int checks = 0, errors = 0;
  bit sent1 = 0;

  always #2.5 clk = ~clk;

  echo_fetch_top dut (.*);

  function automatic logic [SW-1:0] samp(int t, int a);
    return SW'(t * 7919 + a * 2731 + 300);
  endfunction

  function automatic logic [SW-1:0] hword(int t, int h);
    return 16'hC000 | SW'(t << 4) | SW'(h);
  endfunction

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic send_trace(input int t, input bit gaps);
    for (int w = 0; w < HDR + DEPTH; w++) begin
      if (gaps && (w % 5 == 2)) begin
        @(negedge clk);
        trc_valid = 0;
        trc_data  = 16'hDEAD;
        @(posedge clk);
      end
      @(negedge clk);
      while (!trc_ready) @(negedge clk);
      trc_valid = 1;
      trc_data  = (w < HDR) ? hword(t, w) : samp(t, w - HDR);
      @(posedge clk);
    end
    @(negedge clk);
    trc_valid = 0;
  endtask

  task automatic check_coords(input int t, input string req);
    for (int h = 0; h < HDR; h++)
      check(coords_out[h*SW +: SW] == hword(t, h), req, coords_out[h*SW +: SW], hword(t, h));
  endtask

  task automatic run_group(input int e, input int t, output bit rdy_at_done);
    logic [AW-1:0] v [LANES];
    logic [IW-1:0] a [LANES];
    int cyc;
    @(negedge clk);
    while (!idx_ready) @(negedge clk);
    for (int k = 0; k < LANES; k++) begin
      a[k] = IW'((int'(VT[e].ib) + k * int'(VT[e].istep)) % DEPTH);
      v[k] = VT[e].vb + AW'(k) * VT[e].vstep;
      idx_bus[k*IW +: IW] = a[k];
      vox_in[k*AW +: AW]  = v[k];
    end
    idx_valid = 1;
    @(posedge clk);
    @(negedge clk);
    idx_valid = 0;
    cyc = 1;
    while (!grp_done && cyc < 40) begin
      @(negedge clk);
      cyc++;
    end
    check(cyc == 11, "R6 done timing", cyc - 1, 10);
    for (int k = 0; k < LANES; k++) begin
      logic [SW-1:0] s;
      logic [AW-1:0] ex;
      s  = samp(t, int'(a[k]));
      ex = v[k] + {{(AW-SW){s[SW-1]}}, s};
      check(vox_out[k*AW +: AW] == ex, "R7 R9 lane sum", vox_out[k*AW +: AW], ex);
    end
    rdy_at_done = idx_ready;
    @(negedge clk);
    check(grp_done == 0, "R6 single pulse", grp_done, 0);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog R1 actual=hung expected=finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    bit rdy;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check(trc_ready == 1, "R1 trc_ready", trc_ready, 1);
    check(trace_live == 0, "R1 trace_live", trace_live, 0);
    check(idx_ready == 0, "R1 idx_ready", idx_ready, 0);
    check(grp_done == 0, "R1 grp_done", grp_done, 0);
    check(coords_out == '0, "R1 coords", coords_out, 0);
    check(vox_out == '0, "R1 vox_out", vox_out, 0);

    send_trace(0, 0);
    check(trc_ready == 0, "R3 stall after full", trc_ready, 0);
    check(trace_live == 0, "R4 no live before swap", trace_live, 0);
    @(negedge clk);
    check(trace_live == 1, "R4 live after swap", trace_live, 1);
    check_coords(0, "R2 R4 header trace0");
    check(idx_ready == 1, "R5 ready when live", idx_ready, 1);
    check(trc_ready == 1, "R3 writer free after swap", trc_ready, 1);

    for (int e = 0; e < 7; e++) begin
      int t;
      t = (e < 3) ? 0 : (e < 6) ? 1 : 2;
      if (e == 0) fork
        begin send_trace(1, 0); sent1 = 1; end
      join_none
      if (e == 2) begin
        while (!sent1) @(negedge clk);
        check(trc_ready == 0, "R3 full trace waits", trc_ready, 0);
        check_coords(0, "R4 R9 coords held");
        repeat (3) @(negedge clk);
        check(trc_ready == 0, "R3 still stalled", trc_ready, 0);
        check(idx_ready == 1, "R5 group left", idx_ready, 1);
      end
      if (e == 6) begin
        send_trace(2, 1);
        @(negedge clk);
        check_coords(2, "R2 R4 header with gaps");
      end
      run_group(e, t, rdy);
      if (e == 2) begin
        check(rdy == 0, "R8 ready low at last done", rdy, 0);
        check_coords(1, "R4 swap after last group");
        check(idx_ready == 1, "R5 ready on new trace", idx_ready, 1);
      end
      if (e == 5) begin
        check(rdy == 0, "R8 ready low at last done", rdy, 0);
        for (int i = 0; i < 5; i++) begin
          @(negedge clk);
          check(idx_ready == 0, "R8 ready stays low", idx_ready, 0);
          check(trc_ready == 1, "R3 writer open", trc_ready, 1);
        end
        check_coords(1, "R4 no swap without trace");
        check(grp_done == 0, "R10 idle no pulse", grp_done, 0);
      end
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule